// File: doc/BRIEF.md
# Programmable Single-Channel Pulse-Width Timer

This block produces one pulse-width-modulated output from a system clock. Software programs it through two 32-bit word registers on a simple single-cycle bus. The control word sits at offset 0x00 and the count word at offset 0x04. The clock is first divided by a power of two, 2^n. The output then runs for a period of P divided ticks and is high for the first H ticks of each period. The output is active-high and has no polarity option.

New values do not break a running waveform. A value written outside a hold window becomes pending and is taken up at the next period boundary. Software can also set a hold bit to gather a new period, phase and prescaler, then release them as one set. A period or phase of zero is never allowed to run. Any attempt that would make it run turns the channel off and sets a sticky error flag. A one-shot mode stops the channel by itself after a single period.

Top module: `pwm_timer_chan`

## Requirements
- R1: After reset, both registers read 0x0000_0000 and `pwm_out` is low.
- R2: Reads return the programmed values, and every undefined bit reads zero.
  - The count word holds the period in bits 25:16 and the phase in bits 9:0.
  - The control word holds run enable in bit 0, one-shot in bit 4, hold in bit 11, the exponent low bit in bit 15, the exponent upper bits (n>>1) in bits 19:16, and the error flag in bit 31.
  - A write to an unmapped offset changes nothing, and a read of an unmapped offset returns zero.
- R3: When the channel is enabled with phase H < period P and exponent n, cycle t after start (t = 0 is the second cycle after the enabling write) has `pwm_out` high exactly when ((t >> n) mod P) < H.
- R4: When phase H >= period P, `pwm_out` stays high for every cycle while the channel runs.
- R5: Enabling while the pending period or pending phase is zero leaves bit 0 clear, sets bit 31 and keeps `pwm_out` low. Writing 1 to bit 31 clears the flag.
- R6: A count-word write of zero period or zero phase while the channel runs (hold bit clear) clears bit 0 and sets bit 31 on that same edge. `pwm_out` is low from the next cycle on.
- R7: Without hold, a new count or exponent written mid-period takes effect only from the first cycle after the current period ends.
- R8: While the hold bit is set, writes of count and exponent do not affect the waveform, even across period boundaries. After the hold bit is cleared, they all take effect together at the next period boundary.
- R9: With one-shot set, the channel produces exactly one period and then clears bit 0 by itself, leaving `pwm_out` low.
- R10: Writing bit 0 = 0 drives `pwm_out` low from the next cycle. A later enable restarts the waveform from the beginning of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the word register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational while `bus_sel` is high and `bus_wr` is low |
| pwm_out | output | 1 | Active-high pulse output |

## Verification
A wrong count or a stale active setting shows up on `pwm_out` within one period. Either the high run is off by whole divided ticks, or the repetition length differs. The bench therefore compares every cycle of two full periods against the arithmetic pattern.

A pending value applied too early or too late shifts the boundary. That shift is visible in the first cycle after the expected boundary.

A faulty zero guard appears at once in the read-back enable and error bits, and in the output of the next cycle.

// File: rtl/pwmt_pkg.sv
// Package: shared register layout and the setting bundle of the PWM channel.
// Assumes 32-bit word registers and 10-bit period/phase fields.
package pwmt_pkg;
    localparam int REG_W   = 32;
    localparam int CNT_W   = 10;
    localparam int EXP_W   = 5;
    localparam int OFS_CTL = 0;
    localparam int OFS_CNT = 4;
    // control word bit positions
    localparam int B_RUN   = 0;
    localparam int B_ONE   = 4;
    localparam int B_HOLD  = 11;
    localparam int B_ELO   = 15;
    localparam int B_EHI_L = 16;
    localparam int B_EHI_H = 19;
    localparam int B_ERR   = 31;
    // count word field positions
    localparam int B_PER_L = 16;
    localparam int B_PER_H = B_PER_L + CNT_W - 1;
    localparam int B_PH_L  = 0;
    localparam int B_PH_H  = B_PH_L + CNT_W - 1;

    typedef struct packed {
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] phase;
        logic [EXP_W-1:0] expo;
    } tset_t;
endpackage

// File: rtl/pwmt_regs.sv
// Module: register file of the PWM channel. Holds programmed values, the
// pending (committed) set used at period boundaries, hold, one-shot, run and
// error state. Assumes single-cycle bus writes and word-aligned offsets.
module pwmt_regs
    import pwmt_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              period_end,
    output logic              run_o,
    output tset_t             pend_o
);
    tset_t prog_q, prog_n, pend_q, pend_n;
    logic  hold_q, hold_n, one_q, one_n, run_q, run_req, err_q, err_n, bad;
    logic  wr_ctl, wr_cnt;

    // decode the two write strobes
    always_comb begin
        wr_ctl = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_CTL));
        wr_cnt = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_CNT));
    end

    // next programmed, pending and control state, including the zero guard
    always_comb begin
        prog_n = prog_q;
        if (wr_cnt) begin
            prog_n.period = bus_wdata[B_PER_H:B_PER_L];
            prog_n.phase  = bus_wdata[B_PH_H:B_PH_L];
        end
        if (wr_ctl)
            prog_n.expo = {bus_wdata[B_EHI_H:B_EHI_L], bus_wdata[B_ELO]};
        hold_n  = wr_ctl ? bus_wdata[B_HOLD] : hold_q;
        one_n   = wr_ctl ? bus_wdata[B_ONE]  : one_q;
        pend_n  = hold_n ? pend_q : prog_n;
        run_req = wr_ctl ? bus_wdata[B_RUN] : (run_q && !(one_q && period_end));
        bad     = run_req && ((pend_n.period == '0) || (pend_n.phase == '0));
        err_n   = (err_q && !(wr_ctl && bus_wdata[B_ERR])) || bad;
    end

    // register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_q <= '0;
            pend_q <= '0;
            hold_q <= 1'b0;
            one_q  <= 1'b0;
            run_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            prog_q <= prog_n;
            pend_q <= pend_n;
            hold_q <= hold_n;
            one_q  <= one_n;
            run_q  <= run_req && !bad;
            err_q  <= err_n;
        end
    end

    // read mux: programmed values, zeros elsewhere
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (bus_addr == ADDR_W'(OFS_CTL)) begin
                bus_rdata[B_RUN]           = run_q;
                bus_rdata[B_ONE]           = one_q;
                bus_rdata[B_HOLD]          = hold_q;
                bus_rdata[B_ELO]           = prog_q.expo[0];
                bus_rdata[B_EHI_H:B_EHI_L] = prog_q.expo[EXP_W-1:1];
                bus_rdata[B_ERR]           = err_q;
            end else if (bus_addr == ADDR_W'(OFS_CNT)) begin
                bus_rdata[B_PER_H:B_PER_L] = prog_q.period;
                bus_rdata[B_PH_H:B_PH_L]   = prog_q.phase;
            end
        end
    end

    assign run_o  = run_q;
    assign pend_o = pend_q;

    // a running channel never carries a zero pending count (R5, R6)
    assert_no_zero_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (pend_q.period != '0 && pend_q.phase != '0));
    // the error flag rises only together with a stopped channel (R6)
    assert_err_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> !run_q);
    // the pending set is frozen while hold stays set (R8)
    assert_hold_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && $past(hold_q)) |-> $stable(pend_q));
endmodule

// File: rtl/pwmt_prescale.sv
// Module: power-of-two clock prescaler. Emits a one-cycle tick every 2^n
// cycles after a restart. Exponents above PRE_MAX saturate at PRE_MAX.
module pwmt_prescale
    import pwmt_pkg::*;
#(
    parameter int PRE_MAX = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [EXP_W-1:0] expo,
    output logic             tick
);
    localparam int PW = PRE_MAX;
    logic [PW-1:0]  cnt_q, mask;
    logic [PW:0]    full;
    logic [EXP_W-1:0] expo_c;

    // clamp the exponent and build the low-bit mask
    always_comb begin
        expo_c = (expo > EXP_W'(PRE_MAX)) ? EXP_W'(PRE_MAX) : expo;
        full   = ({{PW{1'b0}}, 1'b1} << expo_c) - 1'b1;
        mask   = full[PW-1:0];
        tick   = run && ((cnt_q & mask) == mask);
    end

    // free-running divider, cleared when idle or restarted
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) cnt_q <= '0;
        else                           cnt_q <= cnt_q + 1'b1;
    end

    // idle prescaler sits at zero (R10)
    assert_pre_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));
endmodule

// File: rtl/pwmt_wave.sv
// Module: period/phase counter and output stage. Loads the pending set at
// start and at every period boundary; assumes nonzero counts when enabled.
module pwmt_wave
    import pwmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  tset_t            pend,
    input  logic             tick,
    output logic             load,
    output logic             period_end,
    output logic [EXP_W-1:0] expo_act,
    output logic             pwm_out
);
    tset_t            act_q;
    logic [CNT_W-1:0] cnt_q;
    logic             live_q;

    // boundary and output decode
    always_comb begin
        period_end = live_q && tick && (cnt_q == act_q.period - 1'b1);
        load       = (run && !live_q) || period_end;
        pwm_out    = run && live_q && (cnt_q < act_q.phase);
        expo_act   = act_q.expo;
    end

    // active setting and tick counter
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            act_q  <= '0;
            cnt_q  <= '0;
            live_q <= 1'b0;
        end else if (load) begin
            act_q  <= pend;
            cnt_q  <= '0;
            live_q <= 1'b1;
        end else if (tick) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // counter stays inside the active period (R3)
    assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (cnt_q < act_q.period));
    // active setting changes only at a boundary (R7)
    assert_act_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(live_q) && live_q && !$past(period_end)) |-> $stable(act_q));
    // disabled channel returns to the idle state (R10)
    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!live_q && cnt_q == '0));
endmodule

// File: rtl/pwm_timer_chan.sv
// Module: top of the single-channel PWM timer. Connects the register file,
// prescaler and waveform stage. Assumes one synchronous clock domain.
module pwm_timer_chan
    import pwmt_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int PRE_MAX = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              pwm_out
);
    tset_t            pend;
    logic             run, tick, load, period_end;
    logic [EXP_W-1:0] expo_act;

    pwmt_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .period_end(period_end), .run_o(run), .pend_o(pend)
    );

    pwmt_prescale #(.PRE_MAX(PRE_MAX)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(load),
        .expo(expo_act), .tick(tick)
    );

    pwmt_wave u_wave (
        .clk(clk), .rst_n(rst_n), .run(run), .pend(pend), .tick(tick),
        .load(load), .period_end(period_end), .expo_act(expo_act),
        .pwm_out(pwm_out)
    );
endmodule

// File: tb/pwm_timer_chan_bench.sv
// Bench: register checks, an exhaustive small sweep of period/phase/exponent,
// and timed scenarios for pending, hold, zero guard and one-shot behaviour.
module pwm_timer_chan_bench;
    localparam int CLK_PER = 10;
    localparam int WD_CYC  = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_out;
    int          checks = 0, errors = 0;

    pwm_timer_chan u_pwm_timer_chan (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_out(pwm_out)
    );

    always #(CLK_PER/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive_wr(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic idle();
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // called at a negedge; returns at the next negedge
    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        drive_wr(a, d);
        @(negedge clk);
        idle();
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        idle();
    endtask

    initial begin : watchdog
        repeat (WD_CYC) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        int mism;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(4'h0, rd); chk("R1 ctrl", rd, 32'h0);
        bus_read(4'h4, rd); chk("R1 cnt", rd, 32'h0);
        chk("R1 out", {31'b0, pwm_out}, 32'h0);

        // R2 readback masks and unmapped offset
        bus_write(4'h4, 32'hFFFF_FFFF);
        bus_read(4'h4, rd); chk("R2 cnt mask", rd, 32'h03FF_03FF);
        bus_write(4'h0, 32'hFFF0_FFF0);
        bus_read(4'h0, rd); chk("R2 ctrl mask", rd, 32'h0000_8810);
        bus_write(4'h8, 32'hFFFF_FFFF);
        bus_read(4'h8, rd); chk("R2 unmapped read", rd, 32'h0);
        bus_read(4'h4, rd); chk("R2 unmapped write ignored", rd, 32'h03FF_03FF);
        bus_write(4'h0, 32'h0);

        // R3/R4/R10 sweep of exponent, period, phase
        for (int n = 0; n < 3; n++) begin
            for (int p = 1; p <= 5; p++) begin
                for (int h = 1; h <= 6; h++) begin
                    bus_write(4'h4, (32'(p) << 16) | 32'(h));
                    bus_write(4'h0, 32'h1 | (32'(n & 1) << 15) | (32'(n >> 1) << 16));
                    @(negedge clk);
                    mism = 0;
                    for (int t = 0; t < 2 * p * (1 << n); t++) begin
                        if (pwm_out !== ((((t >> n) % p) < h) ? 1'b1 : 1'b0)) mism++;
                        @(negedge clk);
                    end
                    if (h >= p) chk($sformatf("R4 always high n=%0d p=%0d h=%0d", n, p, h), mism, 0);
                    else        chk($sformatf("R3 pattern n=%0d p=%0d h=%0d", n, p, h), mism, 0);
                    bus_write(4'h0, 32'h0);
                    chk("R10 low after disable", {31'b0, pwm_out}, 32'h0);
                end
            end
        end

        // R5 prohibited enable: zero phase, then zero period
        bus_write(4'h4, 32'h0003_0000);
        bus_write(4'h0, 32'h1);
        bus_read(4'h0, rd); chk("R5 zero phase rejected", rd, 32'h8000_0000);
        chk("R5 out low", {31'b0, pwm_out}, 32'h0);
        bus_write(4'h0, 32'h8000_0000);
        bus_read(4'h0, rd); chk("R5 error cleared", rd, 32'h0);
        bus_write(4'h4, 32'h0000_0002);
        bus_write(4'h0, 32'h1);
        bus_read(4'h0, rd); chk("R5 zero period rejected", rd, 32'h8000_0000);
        bus_write(4'h0, 32'h8000_0000);

        // R6 zero phase written while running
        bus_write(4'h4, 32'h0004_0002);
        bus_write(4'h0, 32'h1);
        @(negedge clk);
        mism = 0;
        for (int t = 0; t < 12; t++) begin
            if (pwm_out !== ((t < 2) ? 1'b1 : 1'b0)) mism++;
            if (t == 2) drive_wr(4'h4, 32'h0004_0000); else idle();
            @(negedge clk);
        end
        chk("R6 output stops", mism, 0);
        bus_read(4'h0, rd); chk("R6 forced off with error", rd, 32'h8000_0000);
        bus_write(4'h0, 32'h8000_0000);

        // R7 mid-period change applies at the boundary
        bus_write(4'h4, 32'h0008_0002);
        bus_write(4'h0, 32'h1);
        @(negedge clk);
        mism = 0;
        for (int t = 0; t < 24; t++) begin
            if (pwm_out !== ((t < 8) ? (t < 2) : (((t - 8) % 4) < 3))) mism++;
            if (t == 3) drive_wr(4'h4, 32'h0004_0003); else idle();
            @(negedge clk);
        end
        chk("R7 boundary update", mism, 0);
        bus_write(4'h0, 32'h0);

        // R8 hold gathers count and exponent, release applies them together
        bus_write(4'h4, 32'h0006_0002);
        bus_write(4'h0, 32'h1);
        @(negedge clk);
        mism = 0;
        for (int t = 0; t < 28; t++) begin
            if (pwm_out !== ((t < 12) ? ((t % 6) < 2) : ((((t - 12) / 2) % 2) < 1))) mism++;
            case (t)
                1: drive_wr(4'h0, 32'h0000_0801);
                2: drive_wr(4'h4, 32'h0002_0001);
                3: drive_wr(4'h0, 32'h0000_8801);
                8: drive_wr(4'h0, 32'h0000_8001);
                default: idle();
            endcase
            @(negedge clk);
        end
        chk("R8 hold and release", mism, 0);
        bus_write(4'h0, 32'h0);

        // R9 one-shot gives one period then stops
        bus_write(4'h4, 32'h0005_0002);
        bus_write(4'h0, 32'h0000_0011);
        @(negedge clk);
        mism = 0;
        for (int t = 0; t < 20; t++) begin
            if (pwm_out !== ((t < 2) ? 1'b1 : 1'b0)) mism++;
            @(negedge clk);
        end
        chk("R9 single period", mism, 0);
        bus_read(4'h0, rd); chk("R9 enable self-cleared", rd, 32'h0000_0010);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule